// File: doc/BRIEF.md
# Handshaked Blocking LIFO Stack

This block is a last-in-first-out store of 32 words with two independent valid/ready ports. A producer offers words on the push side. A consumer takes the most recent word from the pop side. The block never signals an error. A full stack holds the producer off by dropping `push_ready`. An empty stack leaves `pop_valid` low, so a consumer that is waiting simply waits until a word arrives. Each accepted push is confirmed one cycle later by a single-cycle `push_ack` pulse. The producer can use this pulse to know that its word is committed.

Within one clock the push is applied before the pop. A word that is accepted while the consumer is ready is therefore handed straight to the consumer in that same cycle. This holds even when the stack was empty. Stored contents and the fill level are then left untouched.

Control is a three-state fill machine. The states are `ST_EMPTY` (nothing stored), `ST_PARTIAL` (1 to 31 words) and `ST_FULL` (32 words). The transitions are:
- `ST_EMPTY` to `ST_PARTIAL` on a stored push.
- `ST_PARTIAL` to `ST_FULL` on a stored push at 31 words.
- `ST_PARTIAL` to `ST_EMPTY` on a pop from storage at 1 word.
- `ST_FULL` to `ST_PARTIAL` on a pop from storage.

In every other case the machine stays in its current state, including any cycle in which a push passes straight through to a pop.

Top module: `lifo_stack_hs`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low and right after it is released, `pop_valid` is 0, `push_ack` is 0 and `push_ready` is 1 (stack empty).
- R2: A push transfer occurs on a rising edge where `push_valid` and `push_ready` are both 1; `push_ready` is 1 whenever fewer than 32 words are stored.
- R3: With 32 words stored `push_ready` is 0, an offered word is not taken and stays pending, and stored contents are unchanged; it is accepted on the first cycle after a pop frees a slot.
- R4: `pop_valid` is 1 whenever at least one word is stored, and `pop_data` then shows the most recently stored word.
- R5: A pop transfer (`pop_valid` and `pop_ready` both 1 on a rising edge, with no push in that cycle) removes the top word, so the stored count drops by one.
- R6: With nothing stored and no push offered, `pop_valid` is 0 however long `pop_ready` is held; a later push is then delivered to the waiting consumer.
- R7: When a push transfers in a cycle, `pop_valid` is 1 and `pop_data` equals `push_data`; if `pop_ready` is also 1, the consumer receives that word and the stored words and count stay as they were.
- R8: `push_ack` is a one-cycle pulse in the cycle after each accepted push and is 0 in the cycle after any cycle without an accepted push.
- R9: Words leave the stack in the reverse order of their arrival.
- R10: Exactly 32 words can be stored: from empty, with no pops, 32 consecutive offered words are accepted and the 33rd is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Producer offers a word |
| push_ready | output | 1 | Stack can accept a word (not full) |
| push_data | input | DATA_W | Word offered by the producer |
| push_ack | output | 1 | One-cycle confirmation of the previous cycle's accepted push |
| pop_valid | output | 1 | A word is available to the consumer |
| pop_ready | input | 1 | Consumer takes the word shown this cycle |
| pop_data | output | DATA_W | Top word, or the word being pushed this cycle |

## Verification
The stimulus includes the following input patterns:
- A consumer that waits on an empty stack before any push. This separates a correct hold from a spurious pop, and shows that a late push is delivered directly to the consumer.
- Bursts of pushes followed by bursts of pops. These check the ordering, so that a queue-like order cannot pass.
- Filling to the limit with a push still pending, then one pop. This finds off-by-one errors in capacity and in backpressure release.
- Simultaneous push and pop at mid-level, together with long random mixes biased first toward filling and then toward draining. These separate push-before-pop ordering from the opposite priority, and test the fill-state transitions at both ends.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          pop_ready,
    output logic          push_ready,
    output logic          push_fire,
    output logic          pop_valid,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic          push_ack
);

    fill_state_t state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic          rd_en;

    // State register, fill counter and acknowledge flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            count_q  <= '0;
            push_ack <= 1'b0;
        end else begin
            state_q  <= state_d;
            count_q  <= count_d;
            push_ack <= push_fire;
        end
    end

    // Outputs and next-state logic; push is resolved before pop
    always_comb begin
        push_ready = (state_q != ST_FULL);
        push_fire  = push_valid && push_ready;
        pop_valid  = (state_q != ST_EMPTY) || push_fire;
        // a push while the consumer is ready goes straight out
        wr_en      = push_fire && !pop_ready;
        rd_en      = pop_valid && pop_ready && !push_fire;
        wr_idx     = IW'(count_q);
        rd_idx     = IW'(count_q - CW'(1));

        count_d = count_q;
        if (wr_en) begin
            count_d = count_q + CW'(1);
        end else if (rd_en) begin
            count_d = count_q - CW'(1);
        end

        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_en) begin
                    state_d = ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (wr_en && (count_q == CW'(DEPTH - 1))) begin
                    state_d = ST_FULL;
                end else if (rd_en && (count_q == CW'(1))) begin
                    state_d = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (rd_en) begin
                    state_d = ST_PARTIAL;
                end
            end
            default: begin
                state_d = ST_EMPTY;
            end
        endcase
    end

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/lifo_stack_hs.sv
module lifo_stack_hs #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ack,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data
);

    logic              push_fire;
    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic [IW-1:0]     rd_idx;
    logic [DATA_W-1:0] top_word;

    lifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .pop_ready  (pop_ready),
        .push_ready (push_ready),
        .push_fire  (push_fire),
        .pop_valid  (pop_valid),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .push_ack   (push_ack)
    );

    lifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_idx  (rd_idx),
        .rd_data (top_word)
    );

    // the incoming word is on top for the rest of this cycle
    assign pop_data = push_fire ? push_data : top_word;

endmodule

// File: rtl/lifo_stack_hs_chk.sv
module lifo_stack_hs_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              push_ready,
    input logic [DATA_W-1:0] push_data,
    input logic              push_ack,
    input logic              pop_valid,
    input logic              pop_ready,
    input logic [DATA_W-1:0] pop_data
);

    logic          push_xfer, pop_xfer;
    logic [CW-1:0] held;

    assign push_xfer = push_valid && push_ready;
    assign pop_xfer  = pop_valid && pop_ready;

    // independent occupancy count built from the port handshakes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (push_xfer && !pop_xfer) begin
            held <= held + CW'(1);
        end else if (pop_xfer && !push_xfer) begin
            held <= held - CW'(1);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!push_ack && !pop_valid && push_ready));

    assert_ready_capacity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_ready == (held < CW'(DEPTH)));

    assert_idle_ready_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ready && !push_valid && !pop_xfer) |=> push_ready);

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_ready && !pop_xfer) |=> !push_ready);

    assert_stored_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (held != '0) |-> pop_valid);

    assert_empty_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |=> (!pop_valid || push_valid));

    assert_push_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_xfer |-> (pop_valid && (pop_data == push_data)));

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_xfer |=> push_ack);

    assert_no_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !push_xfer |=> !push_ack);

endmodule

bind lifo_stack_hs lifo_stack_hs_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .push_ack   (push_ack),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .pop_data   (pop_data)
);

// File: tb/lifo_stack_hs_tb_top.sv
`timescale 1ns/1ps
module lifo_stack_hs_tb_top;

    localparam int DW    = 32;
    localparam int DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          push_valid = 1'b0;
    logic          push_ready;
    logic [DW-1:0] push_data = '0;
    logic          push_ack;
    logic          pop_valid;
    logic          pop_ready = 1'b0;
    logic [DW-1:0] pop_data;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model[$];
    logic ack_pend = 1'b0;
    logic last_pop = 1'b0;
    int   accepted = 0;
    logic [DW-1:0] seq = 32'h1000_0000;

    always #2 clk = ~clk;

    lifo_stack_hs #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_data  (push_data),
        .push_ack   (push_ack),
        .pop_valid  (pop_valid),
        .pop_ready  (pop_ready),
        .pop_data   (pop_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, compare against the queue model, advance the model
    task automatic step(input bit pv, input bit pr);
        bit exp_pr, pf, exp_pv;
        logic [DW-1:0] exp_pd;
        @(negedge clk);
        push_valid = pv;
        push_data  = seq;
        pop_ready  = pr;
        #1;
        exp_pr = (model.size() < DEPTH);
        check(push_ready == exp_pr,
              (model.size() == DEPTH) ? "R3" : ((model.size() == DEPTH - 1) ? "R10" : "R2"),
              "push_ready", DW'(push_ready), DW'(exp_pr));
        pf     = pv && exp_pr;
        exp_pv = (model.size() > 0) || pf;
        check(pop_valid == exp_pv,
              (model.size() == 0) ? "R6" : (last_pop ? "R5" : "R4"),
              "pop_valid", DW'(pop_valid), DW'(exp_pv));
        if (exp_pv) begin
            exp_pd = pf ? seq : model[$];
            check(pop_data == exp_pd, pf ? "R7" : "R9", "pop_data", pop_data, exp_pd);
        end
        check(push_ack == ack_pend, "R8", "push_ack", DW'(push_ack), DW'(ack_pend));
        if (pf) begin
            model.push_back(seq);
            accepted++;
            seq = seq + 32'd1;
        end
        last_pop = exp_pv && pr;
        if (last_pop) begin
            void'(model.pop_back());
        end
        ack_pend = pf;
    endtask

    initial begin
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        #3;
        check(pop_valid == 1'b0, "R1", "pop_valid in reset", DW'(pop_valid), 0);
        check(push_ack == 1'b0, "R1", "push_ack in reset", DW'(push_ack), 0);
        check(push_ready == 1'b1, "R1", "push_ready in reset", DW'(push_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: consumer waits on an empty stack, then a push goes straight out
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);

        // R9: burst in, burst out
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);

        // R10 / R3: fill from empty, keep offering past the limit
        accepted = 0;
        for (int i = 0; i < 36; i++) step(1'b1, 1'b0);
        check(accepted == DEPTH, "R10", "words accepted from empty",
              DW'(accepted), DW'(DEPTH));
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);

        // R7: simultaneous push and pop at mid level
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 14; i++) step(1'b0, 1'b1);

        // random mixes: fill-biased, then drain-biased
        for (int i = 0; i < 1500; i++) step(($urandom % 4) != 0, ($urandom % 4) == 0);
        for (int i = 0; i < 1500; i++) step(($urandom % 4) == 0, ($urandom % 4) != 0);
        for (int i = 0; i < 1500; i++) step(($urandom % 2) == 0, ($urandom % 2) == 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(800000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule